// File: doc/BRIEF.md
# Two-Level Walsh and M-Sequence Chip Modulator

This block turns a stream of 3-bit data symbols into a baseband chip stream for a direct-sequence acoustic link. Every symbol picks one of eight orthogonal length-8 Walsh codewords. Each Walsh chip is then spread by a fixed 7-chip maximal-length sequence. The result is a composite symbol of 56 chips.

Whenever a Walsh chip is negative, the seven spreading chips in its slot are inverted. After each composite symbol the block stays silent for a guard interval so that multipath echoes can die away. With the default setting the guard lasts as long as the symbol, which halves the useful symbol rate.

Symbols enter through a valid/ready handshake. An external chip-rate enable paces all chip timing, so carrier mixing and the DAC can run downstream at their own rate.

Top module: `wm_spread_mod`

## Requirements
- R1: After reset, `chip_active` and `sym_start` are 0 and `sym_ready` is 1.
- R2: When `sym_valid` and `sym_ready` are both high at a rising clock edge, the symbol is captured. Its first chip is on the outputs directly after that edge, with `chip_active` = 1.
- R3: `chip_sign` = 1 means a −1 chip and 0 means +1. For symbol 0 every 7-chip group is the inner sequence +1 +1 −1 +1 −1 −1 −1, which is sign bits 0,0,1,0,1,1,1 in time order. The inner sequence restarts at the first chip of every Walsh slot.
- R4: For composite chip k (0..55) of symbol s, `chip_sign` = m[k mod 7] XOR parity(s AND (k div 7)), where m is the R3 bit pattern.
- R5: A composite symbol lasts exactly 56 chip enables. After the 56th enable, `chip_active` is 0.
- R6: After the symbol comes a guard of GUARD_CHIPS (default 56) chip enables. During the guard `chip_active` and `sym_ready` are both 0. `sym_ready` returns to 1 only after the last guard enable.
- R7: The state advances only on clock edges where `chip_en` = 1. With `chip_en` low, `chip_sign` and `chip_active` hold their values.
- R8: `sym_start` is 1 only while the first chip (k = 0) of a composite symbol is on the outputs.
- R9: With no symbol offered, chip enables leave `chip_active` at 0 and `sym_ready` at 1.
- R10: Changes on `sym_data` and `sym_valid` while `sym_ready` is 0 do not alter the chips being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | 3 | Symbol value (Walsh row index) |
| sym_ready | output | 1 | Block can take a symbol |
| chip_en | input | 1 | Chip-rate advance pulse |
| chip_sign | output | 1 | Current chip, 1 = −1, 0 = +1 |
| chip_active | output | 1 | A chip is being transmitted |
| sym_start | output | 1 | First chip of a composite symbol |

## Verification
All outputs are decoded combinationally from registered state. A result therefore appears right after the edge that causes it: the first chip follows the accepting edge, and each later chip follows the edge on which `chip_en` was high.

The bench changes inputs one time unit after a rising edge and reads outputs in the same quiet interval. Before every chip enable it compares the chip against the R4 formula. Gaps of several clocks without `chip_en` are inserted and checked for held outputs. The end of the symbol and the end of the guard are sampled on exactly the enable counts that R5 and R6 give.

// File: rtl/wm_spread_mod.sv
module wm_spread_mod #(
  parameter int WALSH_BITS  = 3,
  parameter int GUARD_CHIPS = 56
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sym_valid,
  input  logic [WALSH_BITS-1:0] sym_data,
  output logic                  sym_ready,
  input  logic                  chip_en,
  output logic                  chip_sign,
  output logic                  chip_active,
  output logic                  sym_start
);
  localparam int WALSH_LEN = 1 << WALSH_BITS;
  localparam int MSEQ_LEN  = 7;
  localparam int GW        = $clog2(GUARD_CHIPS + 1);
  localparam logic [2:0] SEED = 3'b100;
  localparam logic [2:0]            M_LAST = 3'(MSEQ_LEN - 1);
  localparam logic [WALSH_BITS-1:0] W_LAST = WALSH_BITS'(WALSH_LEN - 1);
  localparam logic [GW-1:0]         G_LAST = GW'(GUARD_CHIPS - 1);

  typedef enum logic [1:0] {IDLE, SEND, GUARD} st_t;

  st_t                   st;
  logic [2:0]            mcnt;
  logic [WALSH_BITS-1:0] wcnt;
  logic [GW-1:0]         gcnt;
  logic [WALSH_BITS-1:0] sym_q;
  logic [2:0]            lfsr;

  assign sym_ready   = (st == IDLE);
  assign chip_active = (st == SEND);
  assign chip_sign   = chip_active & (lfsr[0] ^ (^(sym_q & wcnt)));
  assign sym_start   = chip_active && (mcnt == 3'd0) && (wcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      mcnt  <= '0;
      wcnt  <= '0;
      gcnt  <= '0;
      sym_q <= '0;
      lfsr  <= SEED;
    end else begin
      case (st)
        IDLE: if (sym_valid) begin
          sym_q <= sym_data;
          mcnt  <= '0;
          wcnt  <= '0;
          lfsr  <= SEED;
          st    <= SEND;
        end
        SEND: if (chip_en) begin
          if (mcnt == M_LAST) begin
            mcnt <= '0;
            lfsr <= SEED;
            if (wcnt == W_LAST) begin
              st   <= GUARD;
              gcnt <= '0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end else begin
            mcnt <= mcnt + 1'b1;
            lfsr <= {lfsr[1] ^ lfsr[0], lfsr[2], lfsr[1]};
          end
        end
        GUARD: if (chip_en) begin
          if (gcnt == G_LAST) st <= IDLE;
          else gcnt <= gcnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_ready |=> sym_start && chip_active);

  p_first_chip_plus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |-> !chip_sign);

  p_lfsr_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 3'b000);

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_active |-> !sym_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en && !sym_ready |=> $stable(chip_sign) && $stable(chip_active));

  p_start_in_symbol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |-> chip_active);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready && !sym_valid |=> !chip_active);
endmodule

// File: tb/wm_spread_mod_test.sv
module wm_spread_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] MPAT = 7'b1110100;

  logic clk = 0, rst_n = 0, sym_valid = 0, chip_en = 0;
  logic [2:0] sym_data = '0;
  logic sym_ready, chip_sign, chip_active, sym_start;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_spread_mod uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_ready(sym_ready), .chip_en(chip_en), .chip_sign(chip_sign),
    .chip_active(chip_active), .sym_start(sym_start)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic en);
    chip_en = en;
    @(posedge clk); #1;
    chip_en = 0;
  endtask

  function automatic logic exp_sign(input logic [2:0] s, input int k);
    logic [2:0] w;
    w = 3'(k / 7);
    return MPAT[k % 7] ^ (^(s & w));
  endfunction

  // Sends one symbol and its guard; gap = idle clocks between enables.
  task automatic send_symbol(input logic [2:0] s, input int gap, input logic poke);
    chk("R2 ready before send", sym_ready, 1'b1);
    sym_valid = 1; sym_data = s;
    @(posedge clk); #1;
    sym_valid = 0;
    chk("R2 active after accept", chip_active, 1'b1);
    for (int k = 0; k < 56; k++) begin
      chk("R4 chip sign", chip_sign, exp_sign(s, k));
      chk("R8 start strobe", sym_start, (k == 0));
      chk("R6 not ready in symbol", sym_ready, 1'b0);
      if (k < 7 && s == 3'd0) chk("R3 inner sequence", chip_sign, MPAT[k]);
      if (poke) begin sym_valid = 1; sym_data = ~s; end
      for (int g = 0; g < gap; g++) begin
        tick(1'b0);
        chk("R7 hold sign", chip_sign, exp_sign(s, k));
        chk("R7 hold active", chip_active, 1'b1);
      end
      if (poke) chk("R10 ignored input", chip_sign, exp_sign(s, k));
      tick(1'b1);
    end
    sym_valid = 0;
    chk("R5 inactive after 56", chip_active, 1'b0);
    for (int g = 0; g < 56; g++) begin
      chk("R6 guard silent", chip_active, 1'b0);
      chk("R6 guard not ready", sym_ready, 1'b0);
      tick(1'b1);
    end
    chk("R6 ready after guard", sym_ready, 1'b1);
  endtask

  task automatic test_reset();
    chk("R1 active", chip_active, 1'b0);
    chk("R1 start", sym_start, 1'b0);
    chk("R1 ready", sym_ready, 1'b1);
  endtask

  task automatic test_idle();
    for (int i = 0; i < 20; i++) begin
      tick(1'b1);
      chk("R9 idle inactive", chip_active, 1'b0);
      chk("R9 idle ready", sym_ready, 1'b1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        test_reset();
        send_symbol(3'd0, 0, 1'b0);
        test_idle();
        send_symbol(3'd5, 2, 1'b1);
        send_symbol(3'd7, 0, 1'b0);
        send_symbol(3'd3, 1, 1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule